// File: doc/BRIEF.md
# Unified TLB Address Translator

This block turns a 32-bit virtual address into a physical address for one of three access kinds: a data read, a data write or an instruction fetch. Two fixed regions never consult the page table. The upper half below 0xC0000000, starting at 0x80000000, is folded down to 29 bits. Everything from 0xE0000000 upward passes through unchanged. For all other addresses, a global enable decides between a plain 29-bit fold and a lookup in a fully associative array of page entries. That array holds pages of four different sizes side by side.

Each entry carries an address-space tag, a shared flag, two protection bits and a dirty bit. A lookup reports the physical address and the granted permissions, or else a fault code that says why the access cannot proceed. On a fault the block latches the faulting address. Except on a multiple hit, it also copies the page-number bits of that address into the page-table-entry-high page field. A software-style entry-load port writes new entries at the slot chosen by a wrap-around replacement counter, and that counter advances on every lookup that reaches the array.

Top module: `utlb_xlate`

## Requirements
- R1: After synchronous active-low reset, `rsp_valid`, `fault_addr`, `pteh_vpn` and `repl_idx` are all zero, and every entry is invalid, so a translated lookup misses.
- R2: An address in 0x80000000..0xBFFFFFFF bypasses the array in privileged mode. Its physical address is the address with bits 31:29 cleared, `rsp_perm` is 3'b111, and `rsp_fault` is 0.
- R3: An address at or above 0xE0000000 bypasses the array and is returned unchanged with full permissions. In user mode this holds only for 0xE0000000..0xE3FFFFFF.
- R4: In user mode (`priv_mode`=0), a bypass address outside 0xE0000000..0xE3FFFFFF faults with code 0x0E0 for a read or fetch and 0x100 for a write.
- R5: With `xlate_on`=0, every non-bypass address is folded to 29 bits with permissions 3'b111, and the replacement counter does not move.
- R6: An entry takes part in a match only when it is valid and its tag equals `cur_asid`. The tag test is skipped when the entry is shared, or when `priv_mode` and `sv_mode` are both 1.
- R7: Size code 0/1/2/3 selects a 1 KB/4 KB/64 KB/1 MB page. The comparison ignores the address bits below the page size. The physical address takes the page frame above the page size and the virtual offset below it.
- R8: Two or more matching entries give code 0x140. No match gives 0x040 for a read or fetch and 0x060 for a write.
- R9: On a hit, protection bit 1 is required in user mode and protection bit 0 is required for a write. A failure gives 0x0A0 for a read or fetch and 0x0C0 for a write. A successful hit grants `rsp_perm` = {exec=1, write=prot[0]&dirty, read=1}, while any fault gives `rsp_perm`=0.
- R10: A write that passes protection to an entry whose dirty bit is clear gives code 0x080.
- R11: On every fault `fault_addr` takes the request address. Except on code 0x140, `pteh_vpn` takes address bits 31:10.
- R12: The counter `repl_idx` advances by one on each request that reaches the array. It returns to 0 when the new value would exceed a non-zero `repl_limit`, or would exceed ENTRIES-1. An asserted `ld_en` writes the entry at the current `repl_idx`.
- R13: A request presented with `req_valid` is answered on `rsp_valid` and the result ports one clock later. Access kind is encoded as 2'b00 read, 2'b01 write, 2'b10 fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| priv_mode | input | 1 | 1 = privileged, 0 = user |
| xlate_on | input | 1 | Enables translation through the array |
| sv_mode | input | 1 | Skip tag check in privileged mode |
| cur_asid | input | 8 | Current address-space tag |
| repl_limit | input | IDXW | Wrap boundary for the counter (0 = none) |
| ld_en | input | 1 | Write an entry at `repl_idx` |
| ld_vpn | input | 22 | Entry virtual page number (address bits 31:10) |
| ld_asid | input | 8 | Entry address-space tag |
| ld_ppn | input | 19 | Entry page frame (physical bits 28:10) |
| ld_size | input | 2 | Entry size code |
| ld_prot | input | 2 | Entry protection bits |
| ld_dirty | input | 1 | Entry dirty bit |
| ld_shared | input | 1 | Entry shared flag |
| ld_valid | input | 1 | Entry valid bit |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_perm | output | 3 | {exec, write, read} |
| rsp_fault | output | 12 | Fault code, 0 when none |
| fault_addr | output | 32 | Last faulting address |
| pteh_vpn | output | 22 | Page field of the page-table-entry-high register |
| repl_idx | output | IDXW | Replacement counter |

## Verification
All results of a request are due exactly one clock after it is presented. These include the response ports, the latched fault address, the page field and the counter step. An entry load lands at the same edge and affects only later lookups. The bench applies each stimulus on a falling edge and advances a behavioural reference model by the same single step. It then compares every output on the next falling edge, half a period after the capturing edge, so every comparison falls in the cycle the result becomes visible. The response fields are compared only when `rsp_valid` is expected. The counter, fault address and page field are compared on every cycle.

// File: rtl/utlb_pkg.sv
// Shared types and fault codes of the unified TLB translator.
// Assumes a 32-bit virtual space and a 29-bit physical frame space.
package utlb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10
    } acc_e;

    localparam logic [11:0] FLT_NONE    = 12'h000;
    localparam logic [11:0] FLT_MISS_RD = 12'h040;
    localparam logic [11:0] FLT_MISS_WR = 12'h060;
    localparam logic [11:0] FLT_INIT_WR = 12'h080;
    localparam logic [11:0] FLT_PROT_RD = 12'h0A0;
    localparam logic [11:0] FLT_PROT_WR = 12'h0C0;
    localparam logic [11:0] FLT_ADDR_RD = 12'h0E0;
    localparam logic [11:0] FLT_ADDR_WR = 12'h100;
    localparam logic [11:0] FLT_MULTI   = 12'h140;

    typedef struct packed {
        logic        valid;
        logic        shared;
        logic        dirty;
        logic [1:0]  prot;
        logic [1:0]  size;
        logic [7:0]  asid;
        logic [21:0] vpn;
        logic [18:0] ppn;
    } tlb_ent_t;

endpackage

// File: rtl/utlb_entry_cmp.sv
// Compare logic for one page entry: decides whether the entry covers
// the address under the tag rules, and forms the physical address it
// would produce. Purely combinational; assumes the entry is stable.
module utlb_entry_cmp
    import utlb_pkg::*;
(
    input  tlb_ent_t    ent,
    input  logic [31:0] vaddr,
    input  logic [7:0]  cur_asid,
    input  logic        skip_asid,
    output logic        hit,
    output logic [28:0] paddr
);
    logic [31:0] off_mask;
    logic [31:0] frame;
    logic        tag_ok;

    // Offset mask for the page size code
    always_comb begin
        unique case (ent.size)
            2'd0:    off_mask = 32'h0000_03FF;
            2'd1:    off_mask = 32'h0000_0FFF;
            2'd2:    off_mask = 32'h0000_FFFF;
            default: off_mask = 32'h000F_FFFF;
        endcase
    end

    // Tag, range match and physical address composition
    always_comb begin
        tag_ok = ent.shared || skip_asid || (ent.asid == cur_asid);
        hit    = ent.valid && tag_ok &&
                 ((vaddr & ~off_mask) == ({ent.vpn, 10'b0} & ~off_mask));
        frame  = ({3'b000, ent.ppn, 10'b0} & ~off_mask) | (vaddr & off_mask);
        paddr  = frame[28:0];
    end

endmodule

// File: rtl/utlb_repl_ctr.sv
// Replacement counter: steps once per array access and wraps to zero
// past a non-zero limit or past the last entry index.
module utlb_repl_ctr #(
    parameter int ENTRIES = 64,
    localparam int IDXW = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic [IDXW-1:0] limit,
    output logic [IDXW-1:0] count
);
    localparam logic [IDXW:0] LAST = (IDXW+1)'(ENTRIES - 1);

    logic [IDXW:0] nxt;
    logic          live;

    // Candidate next value with one guard bit
    always_comb begin
        nxt = {1'b0, count} + 1'b1;
        if (((limit != '0) && (nxt > {1'b0, limit})) || (nxt > LAST))
            nxt = '0;
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (step) count <= nxt[IDXW-1:0];
    end

    // Marks cycles whose previous sample lies after reset
    always_ff @(posedge clk) live <= rst_n;

    // R12
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && !step |=> $stable(count));

    // R12
    wrap_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && step && (limit != '0) && (count >= limit) |=> count == '0);

endmodule

// File: rtl/utlb_xlate.sv
// Unified TLB address translator. Classifies the address into the
// fixed bypass regions, the untranslated fold, or an associative
// lookup; checks tags and protection; registers the result one cycle
// later together with the fault address and page field. Assumes the
// entry-load port and lookups are driven by one master.
module utlb_xlate
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDXW = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [31:0]     req_vaddr,
    input  logic [1:0]      req_kind,
    input  logic            priv_mode,
    input  logic            xlate_on,
    input  logic            sv_mode,
    input  logic [7:0]      cur_asid,
    input  logic [IDXW-1:0] repl_limit,
    input  logic            ld_en,
    input  logic [21:0]     ld_vpn,
    input  logic [7:0]      ld_asid,
    input  logic [18:0]     ld_ppn,
    input  logic [1:0]      ld_size,
    input  logic [1:0]      ld_prot,
    input  logic            ld_dirty,
    input  logic            ld_shared,
    input  logic            ld_valid,
    output logic            rsp_valid,
    output logic [31:0]     rsp_paddr,
    output logic [2:0]      rsp_perm,
    output logic [11:0]     rsp_fault,
    output logic [31:0]     fault_addr,
    output logic [21:0]     pteh_vpn,
    output logic [IDXW-1:0] repl_idx
);
    localparam int CNTW = $clog2(ENTRIES + 1);

    tlb_ent_t          tbl [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic [28:0]       pa_vec [ENTRIES];
    logic [CNTW-1:0]   hit_cnt;
    tlb_ent_t          sel_ent;
    logic [28:0]       sel_pa;
    logic              skip_asid;
    logic              in_fold, in_top, in_sq, bypass, is_wr, lookup;
    logic [31:0]       nx_pa;
    logic [2:0]        nx_perm;
    logic [11:0]       nx_fault;
    logic              live;

    assign skip_asid = priv_mode && sv_mode;

    // Entry storage: cleared on reset, written at the counter slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else if (ld_en) begin
            tbl[repl_idx] <= '{valid: ld_valid, shared: ld_shared,
                               dirty: ld_dirty, prot: ld_prot,
                               size: ld_size, asid: ld_asid,
                               vpn: ld_vpn, ppn: ld_ppn};
        end
    end

    // One comparator per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        utlb_entry_cmp u_cmp (
            .ent       (tbl[g]),
            .vaddr     (req_vaddr),
            .cur_asid  (cur_asid),
            .skip_asid (skip_asid),
            .hit       (hit_vec[g]),
            .paddr     (pa_vec[g])
        );
    end

    // Merge the matching entry (meaningful only for a single hit)
    always_comb begin
        hit_cnt = CNTW'($countones(hit_vec));
        sel_ent = '0;
        sel_pa  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                sel_ent = sel_ent | tbl[i];
                sel_pa  = sel_pa | pa_vec[i];
            end
        end
    end

    // Region decode, protection and fault classification
    always_comb begin
        in_fold  = (req_vaddr[31:30] == 2'b10);
        in_top   = (req_vaddr[31:29] == 3'b111);
        in_sq    = (req_vaddr[31:26] == 6'b111000);
        bypass   = in_fold || in_top;
        is_wr    = (req_kind == ACC_WRITE);
        lookup   = 1'b0;
        nx_pa    = '0;
        nx_perm  = '0;
        nx_fault = FLT_NONE;
        if (bypass) begin
            if (!priv_mode && !in_sq) begin
                nx_fault = is_wr ? FLT_ADDR_WR : FLT_ADDR_RD;
            end else begin
                nx_pa   = in_fold ? {3'b000, req_vaddr[28:0]} : req_vaddr;
                nx_perm = 3'b111;
            end
        end else if (!xlate_on) begin
            nx_pa   = {3'b000, req_vaddr[28:0]};
            nx_perm = 3'b111;
        end else begin
            lookup = 1'b1;
            if (hit_cnt > CNTW'(1))
                nx_fault = FLT_MULTI;
            else if (hit_cnt == '0)
                nx_fault = is_wr ? FLT_MISS_WR : FLT_MISS_RD;
            else if (!priv_mode && !sel_ent.prot[1])
                nx_fault = is_wr ? FLT_PROT_WR : FLT_PROT_RD;
            else if (is_wr && !sel_ent.prot[0])
                nx_fault = FLT_PROT_WR;
            else if (is_wr && !sel_ent.dirty)
                nx_fault = FLT_INIT_WR;
            else begin
                nx_pa   = {3'b000, sel_pa};
                nx_perm = {1'b1, sel_ent.prot[0] & sel_ent.dirty, 1'b1};
            end
        end
    end

    // Replacement counter
    utlb_repl_ctr #(.ENTRIES(ENTRIES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (req_valid && lookup),
        .limit (repl_limit),
        .count (repl_idx)
    );

    // Result register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_perm  <= '0;
            rsp_fault <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_paddr <= nx_pa;
                rsp_perm  <= nx_perm;
                rsp_fault <= nx_fault;
            end
        end
    end

    // Fault address and page field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_addr <= '0;
            pteh_vpn   <= '0;
        end else if (req_valid && (nx_fault != FLT_NONE)) begin
            fault_addr <= req_vaddr;
            if (nx_fault != FLT_MULTI) pteh_vpn <= req_vaddr[31:10];
        end
    end

    // Marks cycles whose previous sample lies after reset
    always_ff @(posedge clk) live <= rst_n;

    // R11
    tea_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && rsp_valid && (rsp_fault != FLT_NONE) |-> fault_addr == $past(req_vaddr));

    // R11
    multi_keeps_pteh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && rsp_valid && (rsp_fault == FLT_MULTI) |-> $stable(pteh_vpn));

    // R9
    fault_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault != FLT_NONE) |-> rsp_perm == 3'b000);

    // R2
    fold_clears_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live && rsp_valid && (rsp_fault == FLT_NONE) &&
        ($past(req_vaddr[31:30]) == 2'b10) |-> rsp_paddr[31:29] == 3'b000);

endmodule

// File: tb/test_utlb_xlate.sv
`timescale 1ns/1ps
module test_utlb_xlate;
    localparam int ENTRIES = 64;
    localparam int IDXW = $clog2(ENTRIES);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [31:0]     req_vaddr = '0;
    logic [1:0]      req_kind = 2'b00;
    logic            priv_mode = 1'b1, xlate_on = 1'b0, sv_mode = 1'b0;
    logic [7:0]      cur_asid = '0;
    logic [IDXW-1:0] repl_limit = '0;
    logic            ld_en = 1'b0;
    logic [21:0]     ld_vpn = '0;
    logic [7:0]      ld_asid = '0;
    logic [18:0]     ld_ppn = '0;
    logic [1:0]      ld_size = '0, ld_prot = '0;
    logic            ld_dirty = 1'b0, ld_shared = 1'b0, ld_valid = 1'b0;
    logic            rsp_valid;
    logic [31:0]     rsp_paddr, fault_addr;
    logic [2:0]      rsp_perm;
    logic [11:0]     rsp_fault;
    logic [21:0]     pteh_vpn;
    logic [IDXW-1:0] repl_idx;

    utlb_xlate #(.ENTRIES(ENTRIES)) i_utlb_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .priv_mode(priv_mode), .xlate_on(xlate_on),
        .sv_mode(sv_mode), .cur_asid(cur_asid), .repl_limit(repl_limit),
        .ld_en(ld_en), .ld_vpn(ld_vpn), .ld_asid(ld_asid), .ld_ppn(ld_ppn),
        .ld_size(ld_size), .ld_prot(ld_prot), .ld_dirty(ld_dirty),
        .ld_shared(ld_shared), .ld_valid(ld_valid), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault),
        .fault_addr(fault_addr), .pteh_vpn(pteh_vpn), .repl_idx(repl_idx)
    );

    int n_tests = 0, n_fail = 0;
    string cur_tag = "R1";

    // Reference model state
    bit          m_v [ENTRIES], m_sh [ENTRIES], m_d [ENTRIES];
    bit [1:0]    m_pr [ENTRIES], m_sz [ENTRIES];
    int unsigned m_asid [ENTRIES], m_vpn [ENTRIES], m_ppn [ENTRIES];
    int unsigned mcnt = 0, mtea = 0, mpteh = 0;
    bit          e_valid = 0;
    int unsigned e_pa = 0, e_perm = 0, e_fault = 0;

    task automatic check(string tag, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic longint unsigned pg_bytes(bit [1:0] code);
        case (code)
            2'd0: return 64'd1024;
            2'd1: return 64'd4096;
            2'd2: return 64'd65536;
            default: return 64'd1048576;
        endcase
    endfunction

    // One model step from the inputs currently applied
    function automatic void model_step();
        longint unsigned a, sz, st, pa;
        int hits, idx;
        bit wr, touch;
        int unsigned flt;
        a = longint'(req_vaddr);
        wr = (req_kind == 2'b01);
        touch = 0; flt = 0; pa = 0; idx = 0; hits = 0;
        e_valid = req_valid;
        if (req_valid) begin
            e_perm = 0;
            if ((a >= 64'h8000_0000 && a < 64'hC000_0000) || a >= 64'hE000_0000) begin
                if (!priv_mode && !(a >= 64'hE000_0000 && a < 64'hE400_0000))
                    flt = wr ? 'h100 : 'h0E0;
                else begin
                    pa = (a < 64'hC000_0000) ? a % 64'h2000_0000 : a;
                    e_perm = 7;
                end
            end else if (!xlate_on) begin
                pa = a % 64'h2000_0000;
                e_perm = 7;
            end else begin
                touch = 1;
                for (int i = 0; i < ENTRIES; i++) begin
                    if (m_v[i] && (m_sh[i] || (priv_mode && sv_mode) || m_asid[i] == cur_asid)) begin
                        sz = pg_bytes(m_sz[i]);
                        st = (longint'(m_vpn[i]) * 1024) / sz * sz;
                        if (a >= st && a <= st + sz - 1) begin
                            hits++;
                            idx = i;
                        end
                    end
                end
                if (hits > 1) flt = 'h140;
                else if (hits == 0) flt = wr ? 'h060 : 'h040;
                else if (!priv_mode && !m_pr[idx][1]) flt = wr ? 'h0C0 : 'h0A0;
                else if (wr && !m_pr[idx][0]) flt = 'h0C0;
                else if (wr && !m_d[idx]) flt = 'h080;
                else begin
                    sz = pg_bytes(m_sz[idx]);
                    pa = (longint'(m_ppn[idx]) * 1024) / sz * sz + (a % sz);
                    e_perm = {1'b1, m_pr[idx][0] & m_d[idx], 1'b1};
                end
            end
            e_fault = flt;
            e_pa = (flt == 0) ? int'(pa) : 0;
            if (flt != 0) begin
                mtea = int'(a);
                if (flt != 'h140) mpteh = int'(a / 1024);
            end
        end
        if (ld_en) begin
            m_v[mcnt] = ld_valid; m_sh[mcnt] = ld_shared; m_d[mcnt] = ld_dirty;
            m_pr[mcnt] = ld_prot; m_sz[mcnt] = ld_size; m_asid[mcnt] = ld_asid;
            m_vpn[mcnt] = ld_vpn; m_ppn[mcnt] = ld_ppn;
        end
        if (touch) begin
            int unsigned n;
            n = mcnt + 1;
            if ((repl_limit != 0 && n > repl_limit) || n > ENTRIES - 1) n = 0;
            mcnt = n;
        end
    endfunction

    // Advance one clock and compare at the following falling edge
    task automatic tick();
        model_step();
        @(negedge clk);
        check("R13", "rsp_valid", rsp_valid, e_valid);
        check("R12", "repl_idx", repl_idx, mcnt);
        check("R11", "fault_addr", fault_addr, mtea);
        check("R11", "pteh_vpn", pteh_vpn, mpteh);
        if (e_valid) begin
            check(cur_tag, "rsp_fault", rsp_fault, e_fault);
            check(cur_tag, "rsp_paddr", rsp_paddr, e_pa);
            check(cur_tag, "rsp_perm", rsp_perm, e_perm);
        end
        req_valid = 1'b0;
        ld_en = 1'b0;
    endtask

    task automatic look(string tag, logic [31:0] a, logic [1:0] k);
        cur_tag = tag;
        req_valid = 1'b1; req_vaddr = a; req_kind = k;
        tick();
    endtask

    task automatic load(logic [31:0] va, logic [7:0] tg, logic [31:0] pa,
                        logic [1:0] sz, logic [1:0] pr, logic d, logic sh);
        cur_tag = "R12";
        ld_en = 1'b1; ld_vpn = va[31:10]; ld_asid = tg; ld_ppn = pa[28:10];
        ld_size = sz; ld_prot = pr; ld_dirty = d; ld_shared = sh; ld_valid = 1'b1;
        tick();
        look("R12", 32'h0FFF_F000, 2'b00);   // unmapped lookup moves the slot
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "rsp_valid", rsp_valid, 0);
        check("R1", "repl_idx", repl_idx, 0);
        check("R1", "fault_addr", fault_addr, 0);
        check("R1", "pteh_vpn", pteh_vpn, 0);
        xlate_on = 1'b1;
        look("R1", 32'h0000_0400, 2'b00);
        // R2 fold region
        look("R2", 32'h8123_4567, 2'b00);
        look("R2", 32'hA765_4321, 2'b01);
        look("R2", 32'h9000_0000, 2'b10);
        // R3 top region
        look("R3", 32'hFF00_0010, 2'b00);
        priv_mode = 1'b0;
        look("R3", 32'hE100_0040, 2'b00);
        look("R3", 32'hE3FF_FFFC, 2'b01);
        // R4 user address errors
        look("R4", 32'h8000_0000, 2'b00);
        look("R4", 32'hBFFF_FFF0, 2'b01);
        look("R4", 32'hF000_0000, 2'b10);
        look("R4", 32'hE400_0000, 2'b01);
        // R5 translation off
        xlate_on = 1'b0; priv_mode = 1'b1;
        look("R5", 32'h4000_1234, 2'b00);
        priv_mode = 1'b0;
        look("R5", 32'h7FFF_FFFF, 2'b01);
        look("R5", 32'hC000_0100, 2'b10);
        // R8 misses
        xlate_on = 1'b1; priv_mode = 1'b1;
        look("R8", 32'h0001_2000, 2'b00);
        look("R8", 32'h0001_2004, 2'b01);
        look("R8", 32'h0001_2008, 2'b10);
        // Entry loads at the counter slot
        load(32'h1000_0000, 8'd5, 32'h0234_5000, 2'd1, 2'b11, 1'b1, 1'b0);
        load(32'h2000_0400, 8'd5, 32'h0001_0C00, 2'd0, 2'b10, 1'b0, 1'b0);
        load(32'h3003_0000, 8'd9, 32'h1ABC_0000, 2'd2, 2'b00, 1'b0, 1'b1);
        load(32'h4057_3C00, 8'd7, 32'h0775_5400, 2'd3, 2'b01, 1'b1, 1'b0);
        load(32'h4051_2000, 8'd7, 32'h0033_3000, 2'd1, 2'b11, 1'b1, 1'b0);
        load(32'h5000_0000, 8'd5, 32'h0044_4000, 2'd1, 2'b11, 1'b0, 1'b0);
        // R6 tag rules
        cur_asid = 8'd5;
        look("R6", 32'h1000_0ABC, 2'b00);
        cur_asid = 8'd6;
        look("R6", 32'h1000_0ABC, 2'b00);
        sv_mode = 1'b1;
        look("R6", 32'h1000_0ABC, 2'b00);
        priv_mode = 1'b0;
        look("R6", 32'h1000_0ABC, 2'b00);
        priv_mode = 1'b1; sv_mode = 1'b0; cur_asid = 8'd1;
        look("R6", 32'h3003_1234, 2'b00);
        // R7 page sizes and offsets
        cur_asid = 8'd5; priv_mode = 1'b0;
        look("R7", 32'h2000_07FF, 2'b00);
        look("R7", 32'h2000_0800, 2'b00);
        priv_mode = 1'b1;
        look("R7", 32'h3003_FFFF, 2'b00);
        cur_asid = 8'd7;
        look("R7", 32'h4057_FFF0, 2'b00);
        look("R7", 32'h405F_FFFF, 2'b01);
        // R8 multiple hit
        look("R8", 32'h4051_2345, 2'b00);
        look("R8", 32'h4051_2FFC, 2'b01);
        // R9 protection
        priv_mode = 1'b0; cur_asid = 8'd9;
        look("R9", 32'h3003_0000, 2'b00);
        look("R9", 32'h3003_0010, 2'b01);
        priv_mode = 1'b1;
        look("R9", 32'h3003_0020, 2'b01);
        priv_mode = 1'b0; cur_asid = 8'd5;
        look("R9", 32'h2000_0500, 2'b00);
        look("R9", 32'h2000_0504, 2'b01);
        look("R9", 32'h1000_0000, 2'b10);
        // R10 first write to a clean page
        priv_mode = 1'b1;
        look("R10", 32'h5000_0010, 2'b01);
        look("R10", 32'h1000_0010, 2'b01);
        // R12 counter wrap with a limit, then the full range
        repl_limit = IDXW'(3);
        for (int i = 0; i < 6; i++) look("R12", 32'h0FFF_0000, 2'b00);
        repl_limit = '0;
        for (int i = 0; i < 70; i++) look("R12", 32'h0FFF_0000, 2'b10);
        // R13 idle cycle
        tick();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule